// File: doc/BRIEF.md
# Two-channel capture/compare timer

An 8-bit timer with two channels. The counter runs up from zero to a programmable top value and then back down to zero, over and over, while a run bit is set. Each channel is set as either an input capture channel or an output compare channel. A capture channel latches the counter value when a selected edge appears on its input pin. A compare channel drives its output pin from a register and sets, clears or toggles that pin when the counter matches the channel value.

Each channel has a sticky event flag, and the counter has a turn-around flag. One interrupt line is high while any flag is set and its mask bit is also set. Software reaches the block through a small register port with eight addresses and one cycle of read latency. The channel 0 compare value is double-buffered and only takes effect when the counter is at zero. The channel 1 compare value takes effect at once.

Top module: `tmr_cc2ch`

## Requirements
- R1: After reset the counter, the flags, both pin outputs and irq are 0. Every address reads 0, except address 1 (top value), which reads 0xFF.
- R2: While running, the counter (read at address 7) steps 0,1,...,T,T-1,...,1,0,1,... where T is the top value at address 1.
- R3: While the run bit (address 0 bit 0) is 0, the counter holds its value and no capture or compare event occurs.
- R4: A channel config (address 2 for channel 0, 3 for channel 1) has bit0 = mode (0 capture, 1 compare), bits 2:1 = select and bit3 = mask. In capture mode, select 01 reacts to rising edges, 10 to falling edges, 11 to both and 00 to none.
- R5: A capture stores the counter value into the channel value register (address 4 or 5). The stored value is the one the counter held two cycles after the pin edge was driven, because of the two-stage synchronizer.
- R6: In compare mode the pin output changes on the clock edge where the counter equals the channel value. Select 01 sets it, 10 clears it, 11 toggles it and 00 leaves it unchanged.
- R7: A write to address 4 goes to a shadow register. That value becomes the active channel 0 compare value only when the counter is 0.
- R8: A write to address 5 changes the channel 1 value at once.
- R9: The flags at address 6 are bit0 = channel 0, bit1 = channel 1 and bit2 = turn-around. They stay set until a write puts 0 in that bit. Writing 1 leaves a flag unchanged, and a new event wins over a clear in the same cycle.
- R10: The turn-around flag sets on the clock edge where the counter, counting up, is at or above the top value.
- R11: irq is high exactly when some flag is set and its mask is set. The turn-around mask is address 0 bit 1.
- R12: Read data appears one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| cap_cmp_in | input | 2 | Capture input pins, one per channel |
| cap_cmp_out | output | 2 | Compare output pins, one per channel |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to bring about is the buffered channel 0 value. The write has to land while the counter is well away from zero, and the readback must come both before and after the counter's next pass through zero. The bench starts the counter with a known top value and keeps its own triangular model of the count, measured in clock edges since the run bit was written. From that model it places the write mid-ramp, reads the old value, and reads again after a full period. The same model gives the exact edge on which a capture latches a value and on which a compare pin moves.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH    = 2;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_TOP  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CFG0 = 3'd2;
  localparam logic [ADDR_W-1:0] A_CFG1 = 3'd3;
  localparam logic [ADDR_W-1:0] A_VAL0 = 3'd4;
  localparam logic [ADDR_W-1:0] A_VAL1 = 3'd5;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd6;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd7;

  // select codes: capture edges / compare actions share one field
  localparam logic [1:0] SEL_OFF = 2'b00;
  localparam logic [1:0] SEL_A   = 2'b01;  // rising / set
  localparam logic [1:0] SEL_B   = 2'b10;  // falling / clear
  localparam logic [1:0] SEL_C   = 2'b11;  // both / toggle

  typedef struct packed {
    logic       mask;
    logic [1:0] sel;
    logic       cmp_mode;
  } ch_cfg_t;

  function automatic logic edge_hit(logic [1:0] sel, logic now, logic prev);
    case (sel)
      SEL_A:   return now & ~prev;
      SEL_B:   return ~now & prev;
      SEL_C:   return now ^ prev;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic apply_act(logic [1:0] sel, logic cur);
    case (sel)
      SEL_A:   return 1'b1;
      SEL_B:   return 1'b0;
      SEL_C:   return ~cur;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/tmr_updown.sv
module tmr_updown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         tc_evt
);
  logic dir_up;

  // returns {next direction, next count}
  function automatic logic [W:0] step(logic [W-1:0] c, logic [W-1:0] t, logic up);
    if (up) begin
      if (c >= t) return {1'b0, (c == '0) ? c : W'(c - 1'b1)};
      else        return {1'b1, W'(c + 1'b1)};
    end else begin
      if (c == '0) return {1'b1, (t == '0) ? c : W'(1)};
      else         return {1'b0, W'(c - 1'b1)};
    end
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else if (run) begin
      {dir_up, cnt} <= step(cnt, top, dir_up);
    end
  end

  assign tc_evt = run && dir_up && (cnt >= top);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (cnt == W'($past(cnt) + 1'b1)) || (cnt == W'($past(cnt) - 1'b1)) || (cnt == $past(cnt)));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan import tmr_pkg::*; #(
  parameter int W        = 8,
  parameter bit BUFFERED = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] cnt,
  input  ch_cfg_t      cfg,
  input  logic         val_we,
  input  logic [W-1:0] wdata,
  input  logic         pin_in,
  output logic         pin_out,
  output logic [W-1:0] ccr,
  output logic         evt_cap,
  output logic         evt_cmp
);
  logic [2:0] sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], pin_in};
  end

  assign evt_cap = run && !cfg.cmp_mode && edge_hit(cfg.sel, sync[1], sync[2]);
  assign evt_cmp = run &&  cfg.cmp_mode && (cnt == ccr);

  generate
    if (BUFFERED) begin : g_buf
      logic [W-1:0] shadow;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          shadow <= '0;
          ccr    <= '0;
        end else begin
          if (val_we) shadow <= wdata;
          if (evt_cap)                          ccr <= cnt;
          else if (cfg.cmp_mode && cnt == '0)   ccr <= shadow;
        end
      end

      // R7
      buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_cap && cnt != '0) |=> $stable(ccr));
    end else begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ccr <= '0;
        else if (evt_cap) ccr <= cnt;
        else if (val_we)  ccr <= wdata;
      end

      // R8
      direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (val_we && !evt_cap) |=> ccr == $past(wdata));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pin_out <= 1'b0;
    else if (evt_cmp) pin_out <= apply_act(cfg.sel, pin_out);
  end

  // R5
  cap_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cap |=> ccr == $past(cnt));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_cmp |=> $stable(pin_out));
endmodule

// File: rtl/tmr_cc2ch.sv
module tmr_cc2ch import tmr_pkg::*; #(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic [NCH-1:0]    cap_cmp_in,
  output logic [NCH-1:0]    cap_cmp_out,
  output logic              irq
);
  localparam int NFLAG = NCH + 1;

  logic            run, tc_mask;
  logic [W-1:0]    top;
  ch_cfg_t         cfg_q [NCH];
  logic [W-1:0]    ccr [NCH];
  logic [NCH-1:0]  val_we, ch_evt, evt_cap, evt_cmp;
  logic [NFLAG-1:0] flags, flag_set, mask_vec;
  logic [W-1:0]    cnt;
  logic            tc_evt;
  logic            flag_wr;

  tmr_updown #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .top(top), .cnt(cnt), .tc_evt(tc_evt)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign val_we[i] = reg_we && (reg_addr == A_VAL0 + ADDR_W'(i));
      tmr_chan #(.W(W), .BUFFERED(i == 0)) u_ch (
        .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt), .cfg(cfg_q[i]),
        .val_we(val_we[i]), .wdata(reg_wdata), .pin_in(cap_cmp_in[i]),
        .pin_out(cap_cmp_out[i]), .ccr(ccr[i]),
        .evt_cap(evt_cap[i]), .evt_cmp(evt_cmp[i])
      );
      assign ch_evt[i]   = evt_cap[i] | evt_cmp[i];
      assign mask_vec[i] = cfg_q[i].mask;
    end
  endgenerate

  assign flag_set      = {tc_evt, ch_evt};
  assign mask_vec[NCH] = tc_mask;
  assign flag_wr       = reg_we && (reg_addr == A_FLAG);
  assign irq           = |(flags & mask_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      tc_mask <= 1'b0;
      top     <= '1;
      for (int i = 0; i < NCH; i++) cfg_q[i] <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CTRL: {tc_mask, run} <= reg_wdata[1:0];
        A_TOP:  top <= reg_wdata;
        A_CFG0: cfg_q[0] <= reg_wdata[3:0];
        A_CFG1: cfg_q[1] <= reg_wdata[3:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags <= '0;
    else if (flag_wr) flags <= (flags & reg_wdata[NFLAG-1:0]) | flag_set;
    else              flags <= flags | flag_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else begin
      case (reg_addr)
        A_CTRL: reg_rdata <= W'({tc_mask, run});
        A_TOP:  reg_rdata <= top;
        A_CFG0: reg_rdata <= W'(cfg_q[0]);
        A_CFG1: reg_rdata <= W'(cfg_q[1]);
        A_VAL0: reg_rdata <= ccr[0];
        A_VAL1: reg_rdata <= ccr[1];
        A_FLAG: reg_rdata <= W'(flags);
        default: reg_rdata <= cnt;
      endcase
    end
  end

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> (flags & $past(flags)) == $past(flags));

  // R11
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && |(flag_set & mask_vec)) |=> irq);

  // R10
  tc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_evt |=> flags[NCH]);
endmodule

// File: tb/sim_tmr_cc2ch.sv
module sim_tmr_cc2ch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] pin_in = '0;
  logic [1:0] pin_out;
  logic       irq;

  int errors = 0;
  int checks = 0;
  int tick = 0;
  int t0 = 0;

  always #4 clk = ~clk;
  always @(posedge clk) tick <= tick + 1;

  tmr_cc2ch u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cap_cmp_in(pin_in), .cap_cmp_out(pin_out), .irq(irq)
  );

  // fields {sel[1:0], level before, level after, flag expected}
  localparam logic [4:0] CAP_VEC [0:6] = '{
    5'b01_0_1_1, 5'b01_1_0_0, 5'b10_1_0_1, 5'b10_0_1_0,
    5'b11_0_1_1, 5'b11_1_0_1, 5'b00_0_1_0
  };

  function automatic int tri_val(int n, int t);
    int p;
    if (t == 0) return 0;
    p = n % (2 * t);
    return (p <= t) ? p : 2 * t - p;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    reg_we = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output int v);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic start_run(logic [7:0] ctrl);
    wr(3'd0, ctrl);
    t0 = tick;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", tick, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v, v2, chg;
    logic prev;
    @(negedge clk);

    // table of capture edge selections
    foreach (CAP_VEC[k]) begin
      pin_in[1] = CAP_VEC[k][2];
      do_reset();
      wr(3'd1, 8'd200);
      wr(3'd3, {5'b0, CAP_VEC[k][4:3], 1'b0});
      start_run(8'h01);
      wait_n(6);
      wr(3'd6, 8'h00);
      pin_in[1] = CAP_VEC[k][1];
      wait_n(6);
      rd(3'd6, v);
      chk($sformatf("R4 vec%0d", k), (v >> 1) & 1, CAP_VEC[k][0]);
    end
    pin_in = '0;

    // R1 reset state and R12 latency
    do_reset();
    reg_addr = 3'd1;
    #1;
    chk("R12 before edge", reg_rdata, 0);
    @(negedge clk);
    chk("R12 after edge", reg_rdata, 255);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk($sformatf("R1 addr%0d", a), v, (a == 1) ? 255 : 0);
    end
    chk("R1 pins", pin_out, 0);
    chk("R1 irq", irq, 0);

    // R2 up/down sequence
    do_reset();
    wr(3'd1, 8'd4);
    start_run(8'h01);
    for (int k = 0; k < 12; k++) begin
      int a;
      a = tick;
      rd(3'd7, v);
      chk("R2 count", v, tri_val(a - t0, 4));
    end

    // R5 capture value, R3 stop
    do_reset();
    wr(3'd1, 8'd200);
    wr(3'd2, 8'h02);
    start_run(8'h01);
    wait_n(10);
    v2 = tick;
    pin_in[0] = 1'b1;
    wait_n(5);
    rd(3'd4, v);
    chk("R5 captured", v, tri_val(v2 + 2 - t0, 200));
    wr(3'd6, 8'h00);
    wr(3'd0, 8'h00);
    pin_in[0] = 1'b0;
    wait_n(5);
    pin_in[0] = 1'b1;
    wait_n(5);
    rd(3'd4, v2);
    chk("R3 no capture when stopped", v2, v);
    rd(3'd6, v2);
    chk("R3 no flag when stopped", v2, 0);
    rd(3'd7, v);
    wait_n(4);
    rd(3'd7, v2);
    chk("R3 count held", v2, v);
    pin_in = '0;

    // R6 compare actions on channel 1
    do_reset();
    wr(3'd1, 8'd10);
    wr(3'd5, 8'd5);
    wr(3'd3, 8'h03);
    start_run(8'h01);
    wait_n(5);
    chk("R6 set not yet", pin_out[1], 0);
    wait_n(1);
    chk("R6 set on match", pin_out[1], 1);
    wr(3'd3, 8'h05);
    wait_n(25);
    chk("R6 clear", pin_out[1], 0);
    chk("R6 ch0 pin idle", pin_out[0], 0);
    wr(3'd3, 8'h07);
    wait_n(2);
    chg = 0;
    prev = pin_out[1];
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (pin_out[1] != prev) chg++;
      prev = pin_out[1];
    end
    chk("R6 toggle count", chg, 4);

    // R7 buffered channel 0, R8 direct channel 1
    do_reset();
    wr(3'd1, 8'd20);
    wr(3'd2, 8'h01);
    start_run(8'h01);
    wait_n(5);
    wr(3'd4, 8'd9);
    rd(3'd4, v);
    chk("R7 not yet loaded", v, 0);
    wait_n(45);
    rd(3'd4, v);
    chk("R7 loaded after zero", v, 9);
    wr(3'd5, 8'd9);
    rd(3'd5, v);
    chk("R8 immediate", v, 9);

    // R9 sticky flags, R11 irq masking
    do_reset();
    wr(3'd1, 8'd200);
    wr(3'd3, 8'h02);
    start_run(8'h01);
    wait_n(4);
    pin_in[1] = 1'b1;
    wait_n(6);
    rd(3'd6, v);
    chk("R9 flag set", v, 2);
    chk("R11 masked irq", irq, 0);
    wr(3'd3, 8'h0A);
    chk("R11 unmasked irq", irq, 1);
    wr(3'd6, 8'hFF);
    wait_n(20);
    rd(3'd6, v);
    chk("R9 write one keeps", v, 2);
    wr(3'd6, 8'h00);
    rd(3'd6, v);
    chk("R9 write zero clears", v, 0);
    chk("R11 irq drops", irq, 0);
    pin_in = '0;

    // R10 turn-around flag with R11 mask
    do_reset();
    wr(3'd1, 8'd3);
    start_run(8'h01);
    rd(3'd6, v);
    chk("R10 not yet", v, 0);
    wait_n(3);
    rd(3'd6, v);
    chk("R10 flag at top", (v >> 2) & 1, 1);
    chk("R11 tc unmasked off", irq, 0);
    wr(3'd0, 8'h03);
    chk("R11 tc irq", irq, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule